// File: doc/BRIEF.md
# Reloading Down-Counter Interval Timer

This block is a single-channel interval timer that sits on a small register bus. Software loads a 32-bit reload constant and a 32-bit count, picks a clock divider, and sets the start bit. From then on the count steps down by one on every divided tick. When a tick arrives while the count is zero, the counter loads the reload constant again and raises a sticky underflow flag. If the interrupt enable is set, it also asserts a level interrupt. The divided tick rate is the module clock divided by four raised to the power (field + 1).

A two-state run machine decides whether ticks reach the counter. In RUN_IDLE the prescaler is held at phase zero and the count holds its value. A write of 1 to the start bit takes the START transition to RUN_ACTIVE. In RUN_ACTIVE the prescaler counts module clocks and emits ticks. A write of 0 to the start bit takes the HALT transition back to RUN_IDLE. Any other write leaves the state unchanged. The count register can be read at any time and returns the live value, so software can compare two reads and see a wrap.

The bus is a single-cycle interface. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are both high. Read data is a combinational function of `bus_addr`. The register addresses are: 0 control, 1 start, 2 reload constant, 3 count.

Top module: `intv_timer`

## Requirements
- R1: After reset, the control and start registers read 0, the count and reload-constant registers read 0xFFFFFFFF, and `irq` is low.
- R2: The reload-constant register (address 2) and the count register (address 3) can be written at any time with any 32-bit value, including all ones, and read back that value.
- R3: While running, the count decreases by one per tick. A tick occurs every 4 << (2 × P) module clocks, where P is control bits 2:0. Values 0, 1, 2 and 3 give 4, 16, 64 and 256. Values 4 to 7 behave as divide by 4 and still read back as written.
- R4: A tick that finds the count at zero loads the reload constant into the count.
- R5: Underflow sets control bit 8. The bit stays set until a control write with bit 8 equal to 0 clears it. A control write with bit 8 equal to 1 leaves the bit unchanged.
- R6: Control bit 5 enables the interrupt, and `irq` is high exactly when bit 8 and bit 5 are both set. With bit 5 clear, counting and the flag still work but `irq` stays low. A clearing write drops `irq` on the same edge that clears the flag.
- R7: Writing 1 to bit 0 of the start register (address 1) starts counting, and writing 0 halts it. The start register reads back the run state in bit 0. While halted, the count holds its value.
- R8: A read of the count while running returns the live counter value, so successive reads show the count falling, then wrapping up to the reload constant.
- R9: The prescaler phase returns to zero when a control write changes bits 2:0, and while the timer is halted. After either event, the next tick comes a full divide period after the first running clock.
- R10: A bus write to the count on the same edge as a tick wins: the count takes the written value and does not decrement or reload.
- R11: If an underflow and a flag-clearing control write fall on the same edge, the flag ends up set.
- R12: Control bits other than 8, 5 and 2:0 ignore writes and read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe; a write happens when this and `bus_sel` are high at a clock edge |
| bus_addr | input | 2 | Register address: 0 control, 1 start, 2 reload constant, 3 count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
The bound checker watches several rules on every cycle. A tick moves the count down by one, or reloads it at zero. A halted timer neither ticks nor changes the count except by a write. A count write always lands. An underflow always leaves the flag set, and the flag only drops on a control write. The interrupt is never high without the flag. Only the directed scenarios can show the exact tick spacing for each divider setting, and the phase restart after a divider change or a stop and restart. The same holds for the cycle-exact collisions: a count write against a tick, and a clearing write against an underflow. The reset values and the bus read-back of every field are also checked only by those scenarios.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_START = 2'd1,
        REG_CONST = 2'd2,
        REG_COUNT = 2'd3
    } reg_sel_e;

    typedef enum logic {
        RUN_IDLE   = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;

    localparam int FLAG_BIT = 8;
    localparam int IE_BIT   = 5;
    localparam int CTRL_W   = 16;
endpackage

// File: rtl/tmr_run_fsm.sv
module tmr_run_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic start_val,
    output logic running
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RUN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_IDLE:   if (start_wr && start_val)  state_d = RUN_ACTIVE; // START
            RUN_ACTIVE: if (start_wr && !start_val) state_d = RUN_IDLE;   // HALT
            default:    state_d = RUN_IDLE;
        endcase
    end

    always_comb begin
        running = (state_q == RUN_ACTIVE);
    end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_MAX = 3,
    parameter int SEL_W   = 3,
    localparam int DIV_W  = 2 * PSC_MAX + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             phase_clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] term;
    int               eff;

    // Reserved selections fold onto the fastest ratio.
    always_comb begin
        eff  = (int'(sel) > PSC_MAX) ? 0 : int'(sel);
        term = {DIV_W{1'b1}} >> (2 * (PSC_MAX - eff));
        tick = run && (phase_q == term);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  phase_q <= '0;
        else if (!run || phase_clr)  phase_q <= '0;
        else if (tick)               phase_q <= '0;
        else                         phase_q <= phase_q + DIV_W'(1);
    end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             underflow
);
    always_comb begin
        underflow = tick && !wr_en && (count == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         count <= '1;
        else if (wr_en)     count <= wr_val;
        else if (underflow) count <= reload_val;
        else if (tick)      count <= count - CNT_W'(1);
    end
endmodule

// File: rtl/intv_timer.sv
module intv_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int PSC_MAX = 3,
    parameter int SEL_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);
    reg_sel_e         sel_reg;
    logic             wr_hit, wr_ctrl, wr_start, wr_const, wr_count;
    logic             running, tick, underflow, field_chg;
    logic [SEL_W-1:0] psc_q;
    logic             ie_q, flag_q;
    logic [CNT_W-1:0] const_q, count_q;
    logic [CTRL_W-1:0] ctrl_view;

    always_comb begin
        sel_reg   = reg_sel_e'(bus_addr);
        wr_hit    = bus_sel && bus_wr;
        wr_ctrl   = wr_hit && (sel_reg == REG_CTRL);
        wr_start  = wr_hit && (sel_reg == REG_START);
        wr_const  = wr_hit && (sel_reg == REG_CONST);
        wr_count  = wr_hit && (sel_reg == REG_COUNT);
        field_chg = wr_ctrl && (bus_wdata[SEL_W-1:0] != psc_q);
    end

    tmr_run_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (wr_start),
        .start_val (bus_wdata[0]),
        .running   (running)
    );

    tmr_prescaler #(.PSC_MAX(PSC_MAX), .SEL_W(SEL_W)) u_psc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (running),
        .phase_clr (field_chg),
        .sel       (psc_q),
        .tick      (tick)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .wr_en      (wr_count),
        .wr_val     (bus_wdata),
        .reload_val (const_q),
        .count      (count_q),
        .underflow  (underflow)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q   <= '0;
            ie_q    <= 1'b0;
            const_q <= '1;
        end else begin
            if (wr_ctrl) begin
                psc_q <= bus_wdata[SEL_W-1:0];
                ie_q  <= bus_wdata[IE_BIT];
            end
            if (wr_const) const_q <= bus_wdata;
        end
    end

    // Underflow outranks a clearing write; writing one leaves the flag alone.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              flag_q <= 1'b0;
        else if (underflow)                      flag_q <= 1'b1;
        else if (wr_ctrl && !bus_wdata[FLAG_BIT]) flag_q <= 1'b0;
    end

    always_comb begin
        ctrl_view              = '0;
        ctrl_view[FLAG_BIT]    = flag_q;
        ctrl_view[IE_BIT]      = ie_q;
        ctrl_view[SEL_W-1:0]   = psc_q;
    end

    always_comb begin
        unique case (sel_reg)
            REG_CTRL:  bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_view};
            REG_START: bus_rdata = {{(CNT_W-1){1'b0}}, running};
            REG_CONST: bus_rdata = const_q;
            REG_COUNT: bus_rdata = count_q;
            default:   bus_rdata = '0;
        endcase
        irq = flag_q && ie_q;
    end
endmodule

// File: rtl/intv_timer_chk.sv
module intv_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             tick,
    input logic             cnt_wr,
    input logic             ctrl_wr,
    input logic             underflow,
    input logic [CNT_W-1:0] wdata,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload,
    input logic             flag,
    input logic             irq
);
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && count != '0) |=> (count == $past(count) - CNT_W'(1)));

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && count == '0) |=> (count == $past(reload)));

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ctrl_wr) |=> flag);

    p_irq_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_wr) |=> (count == $past(count)));

    p_idle_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !tick);

    p_wr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count == $past(wdata)));

    p_uf_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> flag);
endmodule

bind intv_timer intv_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .running   (running),
    .tick      (tick),
    .cnt_wr    (wr_count),
    .ctrl_wr   (wr_ctrl),
    .underflow (underflow),
    .wdata     (bus_wdata),
    .count     (count_q),
    .reload    (const_q),
    .flag      (flag_q),
    .irq       (irq)
);

// File: tb/sim_intv_timer.sv
`timescale 1ns/1ps
module sim_intv_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_fail = 0;

    localparam logic [1:0] A_CTRL = 2'd0, A_START = 2'd1, A_CONST = 2'd2, A_COUNT = 2'd3;

    always #10 clk = ~clk;

    intv_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Drives now (between edges); the write lands on the next rising edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a; bus_wr = 1'b0; bus_sel = 1'b1;
        #1 d = bus_rdata;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_CTRL, d);  chk("R1 ctrl reset", d, 32'h0);
        rd(A_START, d); chk("R1 start reset", d, 32'h0);
        rd(A_CONST, d); chk("R1 const reset", d, 32'hFFFF_FFFF);
        rd(A_COUNT, d); chk("R1 count reset", d, 32'hFFFF_FFFF);
        chk("R1 irq reset", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(A_CONST, 32'h1234_5678); rd(A_CONST, d); chk("R2 const rw", d, 32'h1234_5678);
        wr(A_CONST, 32'hFFFF_FFFF); rd(A_CONST, d); chk("R2 const ones", d, 32'hFFFF_FFFF);
        wr(A_COUNT, 32'hA5A5_0F0F); rd(A_COUNT, d); chk("R2 count rw", d, 32'hA5A5_0F0F);
        wr(A_CTRL, 32'hFFFF_FFFF);  rd(A_CTRL, d);  chk("R12 ctrl unused bits", d, 32'h0000_0027);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_halt();
        logic [31:0] d;
        wr(A_START, 0); wr(A_CTRL, 0); wr(A_COUNT, 32'd10);
        wait_clk(20);
        rd(A_COUNT, d); chk("R7 halted holds", d, 32'd10);
        rd(A_START, d); chk("R7 start reads idle", d, 32'd0);
        wr(A_START, 1);
        rd(A_START, d); chk("R7 start reads run", d, 32'd1);
        wr(A_START, 0);
    endtask

    task automatic t_prescale(input logic [2:0] sel, input int ratio);
        logic [31:0] d;
        wr(A_START, 0); wr(A_CTRL, {29'd0, sel}); wr(A_COUNT, 32'd1000);
        wr(A_START, 1);
        wait_clk(ratio - 1);
        rd(A_COUNT, d); chk($sformatf("R3 sel%0d before tick", sel), d, 32'd1000);
        wait_clk(1);
        rd(A_COUNT, d); chk($sformatf("R3 sel%0d first tick", sel), d, 32'd999);
        wait_clk(ratio);
        rd(A_COUNT, d); chk($sformatf("R3 sel%0d second tick", sel), d, 32'd998);
        wr(A_START, 0);
    endtask

    task automatic t_reload();
        logic [31:0] d;
        wr(A_START, 0); wr(A_CONST, 32'd5); wr(A_COUNT, 32'd1); wr(A_CTRL, 32'h0020);
        wr(A_START, 1);
        wait_clk(4);
        rd(A_COUNT, d); chk("R8 live at zero", d, 32'd0);
        wait_clk(3);
        rd(A_COUNT, d); chk("R8 still zero", d, 32'd0);
        rd(A_CTRL, d);  chk("R5 flag not yet", d, 32'h0020);
        chk("R6 irq not yet", {31'd0, irq}, 32'd0);
        wait_clk(1);
        rd(A_COUNT, d); chk("R4 reloaded", d, 32'd5);
        rd(A_CTRL, d);  chk("R5 flag set", d, 32'h0120);
        chk("R6 irq raised", {31'd0, irq}, 32'd1);
        wr(A_START, 0);
        wr(A_CTRL, 32'h0120);
        rd(A_CTRL, d);  chk("R5 write one keeps flag", d, 32'h0120);
        chk("R6 irq kept", {31'd0, irq}, 32'd1);
        wr(A_CTRL, 32'h0020);
        rd(A_CTRL, d);  chk("R5 write zero clears", d, 32'h0020);
        chk("R6 irq dropped", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_noirq();
        logic [31:0] d;
        wr(A_START, 0); wr(A_CTRL, 0); wr(A_CONST, 32'd3); wr(A_COUNT, 32'd0);
        wr(A_START, 1);
        wait_clk(4);
        rd(A_COUNT, d); chk("R6 runs without ie", d, 32'd3);
        rd(A_CTRL, d);  chk("R6 flag without ie", d, 32'h0100);
        chk("R6 no irq without ie", {31'd0, irq}, 32'd0);
        wr(A_START, 0); wr(A_CTRL, 0);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        wr(A_START, 0); wr(A_CTRL, 0); wr(A_COUNT, 32'd50);
        wr(A_START, 1);
        wait_clk(3);
        wr(A_COUNT, 32'd100);
        rd(A_COUNT, d); chk("R10 write beats tick", d, 32'd100);
        wait_clk(3);
        rd(A_COUNT, d); chk("R10 next tick pending", d, 32'd100);
        wait_clk(1);
        rd(A_COUNT, d); chk("R10 next tick", d, 32'd99);
        wr(A_START, 0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        wr(A_START, 0); wr(A_CTRL, 32'h0020); wr(A_CONST, 32'd9); wr(A_COUNT, 32'd0);
        wr(A_START, 1);
        wait_clk(3);
        wr(A_CTRL, 32'h0020);
        rd(A_CTRL, d);  chk("R11 underflow beats clear", d, 32'h0120);
        chk("R11 irq high", {31'd0, irq}, 32'd1);
        rd(A_COUNT, d); chk("R4 reload on collide", d, 32'd9);
        wr(A_START, 0); wr(A_CTRL, 0);
    endtask

    task automatic t_phase();
        logic [31:0] d;
        wr(A_START, 0); wr(A_CTRL, 32'h0001); wr(A_COUNT, 32'd500);
        wr(A_START, 1);
        wait_clk(10);
        wr(A_CTRL, 32'h0000);
        wait_clk(3);
        rd(A_COUNT, d); chk("R9 field change restarts phase", d, 32'd500);
        wait_clk(1);
        rd(A_COUNT, d); chk("R9 tick after field change", d, 32'd499);
        wait_clk(2);
        wr(A_START, 0);
        wr(A_START, 1);
        wait_clk(3);
        rd(A_COUNT, d); chk("R9 stop restarts phase", d, 32'd499);
        wait_clk(1);
        rd(A_COUNT, d); chk("R9 tick after restart", d, 32'd498);
        wr(A_START, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_halt();
        t_prescale(3'd0, 4);
        t_prescale(3'd1, 16);
        t_prescale(3'd2, 64);
        t_prescale(3'd3, 256);
        t_prescale(3'd5, 4);
        t_reload();
        t_noirq();
        t_priority();
        t_collide();
        t_phase();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule